// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block produces the instruction-cycle timing of a small microcontroller core. Every four periods of the oscillator clock make one instruction cycle. The cycle is split into four phases, Q1 through Q4, which follow each other. Exactly one phase strobe is high at any time. The block holds the program counter and the instruction register, and it overlaps fetch with execute in a two-stage pipeline. In each cycle it puts one address on the program-memory bus and latches the returned word. In the following cycle it presents that word, with its address and an execute-valid flag, to the core's decode and execute logic.

The phase sequencer is a four-state machine with states PH_Q1, PH_Q2, PH_Q3 and PH_Q4. Its only transitions are ADV_Q1_Q2, ADV_Q2_Q3, ADV_Q3_Q4 and WRAP_Q4_Q1, one taken on every clock, and reset forces PH_Q1. In PH_Q1 the state machine raises the advance command, so the address register takes the current count and the counter steps. In PH_Q4 it raises the latch command, so the instruction register takes the memory word. A quarter-rate clock output is formed from the phase. A flush input, sampled at the end of Q4, marks the word just fetched as void for the next cycle.

Top module: `quad_phase_sequencer`

## Requirements
- R1: One instruction cycle lasts four oscillator clocks, one per phase in PH_Q1, PH_Q2, PH_Q3, PH_Q4 order, and the first clock after reset is released is Q1 of cycle 0.
- R2: `phase_o` is one-hot at every clock (bit 0 = Q1, bit 1 = Q2, bit 2 = Q3, bit 3 = Q4) and moves Q1→Q2→Q3→Q4→Q1.
- R3: `fetch_addr_o` changes only on the clock edge that ends Q1. During Q2–Q4 of cycle k it holds k (modulo 2^ADDR_W), and it keeps that value through Q1 of cycle k+1.
- R4: `instr_o` takes `pmem_data_i` only on the edge that ends Q4 and holds its value otherwise.
- R5: During cycle k+1, `instr_o` is the word read at address k and `instr_addr_o` is k. From Q2 onward, `instr_addr_o + 1 == fetch_addr_o`.
- R6: Reset (active low, asynchronous) puts the block in phase Q1 with `fetch_addr_o`, `instr_o`, `instr_addr_o`, `exec_valid_o` and `clk_div_o` all zero. `exec_valid_o` first rises at the start of cycle 1.
- R7: `clk_div_o` is low in Q1 and Q2 and high in Q3 and Q4.
- R8: `flush_i` high at the edge ending Q4 of cycle k drives `exec_valid_o` low for all of cycle k+1. Addresses fetched afterwards are unchanged: cycle k+1 still fetches k+1.
- R9: The program counter is ADDR_W bits (13 by default) and wraps from 2^ADDR_W−1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard the word being fetched (sampled at end of Q4) |
| fetch_addr_o | output | ADDR_W | Program-memory address |
| pmem_data_i | input | WORD_W | Program-memory read data for `fetch_addr_o` |
| instr_o | output | WORD_W | Instruction register |
| instr_addr_o | output | ADDR_W | Address of the word in `instr_o` |
| exec_valid_o | output | 1 | `instr_o` is to be executed this cycle |
| phase_o | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| clk_div_o | output | 1 | Quarter-rate clock output |

## Verification
The memory model returns a different word for every address, so a word latched one cycle early or late shows up as a mismatch against the queued item. An unbroken run that crosses the address wrap separates correct modular stepping from a counter that stalls or overflows at the top. Flushes are applied alone and on two cycles in a row. This shows that a flush voids only the next cycle's word, that back-to-back flushes void one word each, and that neither flush moves the fetch address.

// File: rtl/qps_pkg.sv
package qps_pkg;

    localparam int NUM_PHASES = 4;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef struct packed {
        logic advance;   // step the counter (Q1)
        logic latch;     // capture the fetched word (Q4)
    } seq_cmd_t;

endpackage

// File: rtl/qps_phase_fsm.sv
module qps_phase_fsm
    import qps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NUM_PHASES-1:0] strobe_o,
    output logic                  clk_div_o,
    output seq_cmd_t              cmd_o
);

    phase_e state_q;
    phase_e state_d;

    // next-state: ADV_Q1_Q2, ADV_Q2_Q3, ADV_Q3_Q4, WRAP_Q4_Q1
    always_comb begin
        unique case (state_q)
            PH_Q1:   state_d = PH_Q2;
            PH_Q2:   state_d = PH_Q3;
            PH_Q3:   state_d = PH_Q4;
            PH_Q4:   state_d = PH_Q1;
            default: state_d = PH_Q1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_Q1;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from the state
    always_comb begin
        strobe_o  = '0;
        clk_div_o = 1'b0;
        cmd_o     = '0;
        unique case (state_q)
            PH_Q1: begin
                strobe_o[0]   = 1'b1;
                cmd_o.advance = 1'b1;
            end
            PH_Q2: begin
                strobe_o[1] = 1'b1;
            end
            PH_Q3: begin
                strobe_o[2] = 1'b1;
                clk_div_o   = 1'b1;
            end
            PH_Q4: begin
                strobe_o[3] = 1'b1;
                clk_div_o   = 1'b1;
                cmd_o.latch = 1'b1;
            end
            default: begin
                strobe_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/qps_pc_unit.sv
module qps_pc_unit #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] fetch_addr_o
);

    logic [ADDR_W-1:0] count_q;
    logic [ADDR_W-1:0] addr_q;

    // the count runs one ahead of the fetch address; both wrap modulo 2^ADDR_W
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            addr_q  <= '0;
        end else if (advance_i) begin
            addr_q  <= count_q;
            count_q <= count_q + 1'b1;
        end
    end

    assign fetch_addr_o = addr_q;

endmodule

// File: rtl/qps_ir_stage.sv
module qps_ir_stage #(
    parameter int ADDR_W = 13,
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_i,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] instr_o,
    output logic [ADDR_W-1:0] instr_addr_o,
    output logic              valid_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_o      <= '0;
            instr_addr_o <= '0;
            valid_o      <= 1'b0;
        end else if (latch_i) begin
            instr_o      <= word_i;
            instr_addr_o <= fetch_addr_i;
            valid_o      <= !flush_i;
        end
    end

endmodule

// File: rtl/quad_phase_sequencer.sv
module quad_phase_sequencer
    import qps_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic [WORD_W-1:0] pmem_data_i,
    output logic [WORD_W-1:0] instr_o,
    output logic [ADDR_W-1:0] instr_addr_o,
    output logic              exec_valid_o,
    output logic [3:0]        phase_o,
    output logic              clk_div_o
);

    seq_cmd_t              cmd;
    logic [NUM_PHASES-1:0] strobes;

    qps_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_o  (strobes),
        .clk_div_o (clk_div_o),
        .cmd_o     (cmd)
    );

    qps_pc_unit #(.ADDR_W(ADDR_W)) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .advance_i    (cmd.advance),
        .fetch_addr_o (fetch_addr_o)
    );

    qps_ir_stage #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ir (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch_i      (cmd.latch),
        .flush_i      (flush_i),
        .fetch_addr_i (fetch_addr_o),
        .word_i       (pmem_data_i),
        .instr_o      (instr_o),
        .instr_addr_o (instr_addr_o),
        .valid_o      (exec_valid_o)
    );

    assign phase_o = strobes;

endmodule

// File: rtl/quad_phase_sequencer_chk.sv
module quad_phase_sequencer_chk #(
    parameter int ADDR_W = 13,
    parameter int WORD_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic [WORD_W-1:0] instr_o,
    input logic [ADDR_W-1:0] instr_addr_o,
    input logic              exec_valid_o,
    input logic [3:0]        phase_o,
    input logic              clk_div_o
);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_o) == 1);

    p_q1_to_q2_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o[0] |=> phase_o[1]);

    p_q4_to_q1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o[3] |=> phase_o[0]);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_o[0] |=> $stable(fetch_addr_o));

    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o[0] && exec_valid_o) |=>
            fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1'b1));

    p_ir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_o[3] |=> $stable(instr_o));

    p_trail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid_o && !phase_o[0]) |->
            ADDR_W'(instr_addr_o + 1'b1) == fetch_addr_o);

    p_div_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_div_o == (phase_o[2] || phase_o[3]));

    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o[3] && flush_i) |=> !exec_valid_o);

endmodule

bind quad_phase_sequencer quad_phase_sequencer_chk #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .fetch_addr_o (fetch_addr_o),
    .instr_o      (instr_o),
    .instr_addr_o (instr_addr_o),
    .exec_valid_o (exec_valid_o),
    .phase_o      (phase_o),
    .clk_div_o    (clk_div_o)
);

// File: tb/quad_phase_sequencer_tb.sv
`timescale 1ns/1ps
module quad_phase_sequencer_tb;

    localparam int ADDR_W = 13;
    localparam int WORD_W = 14;
    localparam int SPAN   = 1 << ADDR_W;
    localparam int NCYC   = SPAN + 12;

    typedef struct {
        int  addr;
        int  word;
        bit  voided;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush_i = 1'b0;
    logic [ADDR_W-1:0] fetch_addr_o;
    logic [WORD_W-1:0] pmem_data_i;
    logic [WORD_W-1:0] instr_o;
    logic [ADDR_W-1:0] instr_addr_o;
    logic              exec_valid_o;
    logic [3:0]        phase_o;
    logic              clk_div_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  n        = 0;
    bit  run      = 1'b0;
    bit  done     = 1'b0;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    function automatic int mem_word(int a);
        return (a * 37 + 11) & ((1 << WORD_W) - 1);
    endfunction

    function automatic bit is_flush(int k);
        return (k == 5) || (k == 20) || (k == 21) || (k == SPAN - 1);
    endfunction

    assign pmem_data_i = WORD_W'(mem_word(int'(fetch_addr_o)));

    quad_phase_sequencer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .fetch_addr_o (fetch_addr_o),
        .pmem_data_i  (pmem_data_i),
        .instr_o      (instr_o),
        .instr_addr_o (instr_addr_o),
        .exec_valid_o (exec_valid_o),
        .phase_o      (phase_o),
        .clk_div_o    (clk_div_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // driver: queue the expected instruction-register content for fetch cycle k
    task automatic push_expected(input int k);
        item_t it;
        it.addr   = k % SPAN;
        it.word   = mem_word(k % SPAN);
        it.voided = is_flush(k);
        exp_q.push_back(it);
    endtask

    task automatic check_reset_state(input string tag);
        chk(phase_o == 4'b0001, "R6", {tag, " phase"}, int'(phase_o), 1);
        chk(fetch_addr_o == '0, "R6", {tag, " fetch_addr"}, int'(fetch_addr_o), 0);
        chk(instr_o == '0, "R6", {tag, " instr"}, int'(instr_o), 0);
        chk(instr_addr_o == '0, "R6", {tag, " instr_addr"}, int'(instr_addr_o), 0);
        chk(exec_valid_o == 1'b0, "R6", {tag, " exec_valid"}, int'(exec_valid_o), 0);
        chk(clk_div_o == 1'b0, "R7", {tag, " clk_div in reset"}, int'(clk_div_o), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // monitor: one sample per oscillator clock, away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            if (run) begin
                int k;
                int p;
                int exp_addr;
                bit exp_valid;
                n++;
                k = n / 4;
                p = n % 4;
                chk(phase_o == 4'(1 << p), "R2", "phase strobe", int'(phase_o), 1 << p);
                chk(clk_div_o == (p >= 2), "R7", "clk_div level", int'(clk_div_o), int'(p >= 2));
                if (p == 0) exp_addr = (k == 0) ? 0 : (k - 1) % SPAN;
                else        exp_addr = k % SPAN;
                chk(int'(fetch_addr_o) == exp_addr, "R3", "fetch address", int'(fetch_addr_o), exp_addr);
                if (k == SPAN && p == 1)
                    chk(fetch_addr_o == '0, "R9", "address wrap to zero", int'(fetch_addr_o), 0);
                exp_valid = (k == 0) ? 1'b0 : !is_flush(k - 1);
                chk(exec_valid_o == exp_valid, (k > 0 && is_flush(k - 1)) ? "R8" : "R6",
                    "exec_valid", int'(exec_valid_o), int'(exp_valid));
                if (p == 2 && k >= 1) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5", "scoreboard empty", 0, 1);
                    end else begin
                        item_t it;
                        it = exp_q.pop_front();
                        if (!it.voided) begin
                            chk(int'(instr_o) == it.word, "R4", "instruction word", int'(instr_o), it.word);
                            chk(int'(instr_addr_o) == it.addr, "R5", "instruction address",
                                int'(instr_addr_o), it.addr);
                            chk(ADDR_W'(instr_addr_o + 1'b1) == fetch_addr_o, "R5", "execute trails fetch",
                                int'(instr_addr_o), int'(fetch_addr_o) - 1);
                        end
                    end
                end
                // stimulus: flush at the Q4 edge of selected fetch cycles
                flush_i = (p == 3) && is_flush(k);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", n, 4 * NCYC);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check_reset_state("R6 after power-on reset");
        for (int k = 0; k < NCYC; k++) push_expected(k);
        rst_n = 1'b1;
        #1 run = 1'b1;
        wait (n >= 4 * NCYC);
        run = 1'b0;
        flush_i = 1'b0;
        chk(n == 4 * NCYC, "R1", "clocks in run", n, 4 * NCYC);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state("R6 after mid-run reset");
        @(negedge clk);
        finish_run();
    end

endmodule